// File: doc/BRIEF.md
# Serial Peripheral Interrupt Register Group

This block holds the interrupt bookkeeping of a serial peripheral and decodes the register window of that peripheral on a simple 32-bit register bus. Seven event inputs from the datapath set latched status bits. Software clears pending bits by writing ones to the status register. It arms interrupts by writing ones to an enable register and disarms them by writing ones to a separate disable register. A read-only register shows the current mask. One interrupt line is raised when any pending bit is also enabled. The event inputs may be one-cycle pulses or held levels; a held level keeps its bit set, so software can poll the receive-not-empty bit to drain a queue.

The same bus also reaches the neighbouring registers of the peripheral, which live outside this block. The block turns those accesses into one-hot write and read strobes, passes the write data through, and returns the neighbour's read data. A one-bit controller enable register is held here. Every bus request is accepted in the cycle it is presented; there is no back-pressure and no ready signal. Each read is answered by a response beat one cycle later, and the response side cannot stall.

Top module: `serial_irq_regfile`

## Requirements
- R1: After reset the status bits, the mask bits, `ctl_enable`, `irq` and `rsp_valid` are all 0.
- R2: A request is decoded only when its two low address bits are 0. Word offsets: 0x00 control, 0x04 status, 0x08 enable, 0x0C disable, 0x10 mask, 0x14 controller enable, 0x18 delay, 0x1C TX data, 0x20 RX data, 0x24 idle count, 0x28 TX watermark. Any other address is unmapped: a write there changes nothing and a read returns 0.
- R3: In a write to enable (0x08), each 1 bit sets that mask bit. In a write to disable (0x0C), each 1 bit clears that mask bit. Bits written as 0 leave the mask unchanged, and the mask changes at no other time.
- R4: Mask (0x10) is read-only and returns the mask in bits 6:0, so a write there has no effect. Enable and disable read as 0.
- R5: Status (0x04) returns the pending bits in bits 6:0, with upper bits 0. Events use these bit positions in all four registers: bit 1 mode fault, bit 2 TX below watermark, bit 3 TX full, bit 4 RX not empty; bits 0, 5 and 6 are general events. A 1 on `evt_in[i]` sets bit i at the next clock edge. Writing a 1 to status bit i clears it, and a pending bit is never cleared any other way.
- R6: `irq` is the registered OR over all bits of (status AND mask). It rises or falls one clock after the status or mask change that causes it.
- R7: When a clear write and an event hit the same bit in the same cycle, the bit stays set.
- R8: While a level event is held high, the bit cannot be cleared. Once the level drops, the bit stays latched until software clears it.
- R9: Controller enable (0x14) stores write-data bit 0, drives `ctl_enable`, and reads back in bit 0 with the other bits 0.
- R10: A write to a neighbour register drives exactly one bit of `ext_wr_sel` in that same cycle, with `ext_wdata` equal to the request data. The slot order is control 0, delay 1, TX data 2, RX data 3, idle count 4, TX watermark 5.
- R11: A read of a neighbour register drives exactly one bit of `ext_rd_sel` in that cycle, using the slot order of R10. The response then carries the `ext_rdata` value present in the request cycle.
- R12: `rsp_valid` is high in the cycle after each read request and low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present (always accepted) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response beat |
| rsp_rdata | output | 32 | Read response data |
| evt_in | input | NEVT | Event pulses or levels from the datapath |
| ext_wr_sel | output | 6 | One-hot write strobe to neighbour registers |
| ext_rd_sel | output | 6 | One-hot read strobe to neighbour registers |
| ext_wdata | output | 32 | Write data to neighbour registers |
| ext_rdata | input | 32 | Read data from the selected neighbour register |
| ctl_enable | output | 1 | Controller enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: seven events and an 8-bit address. With these values every mask value and every event pattern can be swept, and each is paired with computed clear and disable patterns. Every one of the 256 byte addresses can also be decoded for both reads and writes. This covers all of the offset decoding, including misaligned and unmapped addresses. The interrupt output is checked for every mask and status combination, and its one-cycle lag is checked in a separate test. The same-cycle conflict between an event and a clear, and a held level, are driven on purpose.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_STAT,
    K_EN,
    K_DIS,
    K_MASK,
    K_CEN,
    K_EXT
  } reg_kind_e;

  localparam int unsigned N_EXT     = 6;
  localparam int unsigned EXT_IDX_W = 3;

  // word indices (byte offset / 4)
  localparam int unsigned WD_CTRL  = 0;
  localparam int unsigned WD_STAT  = 1;
  localparam int unsigned WD_EN    = 2;
  localparam int unsigned WD_DIS   = 3;
  localparam int unsigned WD_MASK  = 4;
  localparam int unsigned WD_CEN   = 5;
  localparam int unsigned WD_DLY   = 6;
  localparam int unsigned WD_TXD   = 7;
  localparam int unsigned WD_RXD   = 8;
  localparam int unsigned WD_IDLE  = 9;
  localparam int unsigned WD_WMARK = 10;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output reg_kind_e            kind,
  output logic [EXT_IDX_W-1:0] ext_slot
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    kind     = K_NONE;
    ext_slot = '0;
    if (aligned) begin
      case (word)
        WORD_W'(WD_CTRL):  begin kind = K_EXT; ext_slot = EXT_IDX_W'(0); end
        WORD_W'(WD_STAT):  kind = K_STAT;
        WORD_W'(WD_EN):    kind = K_EN;
        WORD_W'(WD_DIS):   kind = K_DIS;
        WORD_W'(WD_MASK):  kind = K_MASK;
        WORD_W'(WD_CEN):   kind = K_CEN;
        WORD_W'(WD_DLY):   begin kind = K_EXT; ext_slot = EXT_IDX_W'(1); end
        WORD_W'(WD_TXD):   begin kind = K_EXT; ext_slot = EXT_IDX_W'(2); end
        WORD_W'(WD_RXD):   begin kind = K_EXT; ext_slot = EXT_IDX_W'(3); end
        WORD_W'(WD_IDLE):  begin kind = K_EXT; ext_slot = EXT_IDX_W'(4); end
        WORD_W'(WD_WMARK): begin kind = K_EXT; ext_slot = EXT_IDX_W'(5); end
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sirq_status_bank.sv
module sirq_status_bank #(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic [NEVT-1:0] clr,
  output logic [NEVT-1:0] stat
);
  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (evt[i]) q <= 1'b1;        // event beats a clear
      else if (clr[i]) q <= 1'b0;
    end
    assign stat[i] = q;
  end
endmodule

// File: rtl/sirq_mask_bank.sv
module sirq_mask_bank #(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] set_v,
  input  logic [NEVT-1:0] clr_v,
  output logic [NEVT-1:0] mask
);
  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_v[i]) q <= 1'b1;
      else if (clr_v[i]) q <= 1'b0;
    end
    assign mask[i] = q;
  end
endmodule

// File: rtl/sirq_irq_gate.sv
module sirq_irq_gate #(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] stat,
  input  logic [NEVT-1:0] mask,
  output logic            irq
);
  logic any_hit;
  assign any_hit = |(stat & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_hit;
  end
endmodule

// File: rtl/serial_irq_regfile.sv
module serial_irq_regfile
  import sirq_pkg::*;
#(
  parameter int unsigned NEVT   = 7,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NEVT-1:0]   evt_in,
  output logic [5:0]        ext_wr_sel,
  output logic [5:0]        ext_rd_sel,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  output logic              ctl_enable,
  output logic              irq
);
  reg_kind_e            kind;
  logic [EXT_IDX_W-1:0] ext_slot;
  logic                 wr_go, rd_go;
  logic [NEVT-1:0]      wbits;
  logic [NEVT-1:0]      stat_q, mask_q;
  logic [NEVT-1:0]      st_clr, mk_set, mk_clr;
  logic                 cen_q;
  logic [31:0]          rd_mux;

  assign wr_go = req_valid &  req_write;
  assign rd_go = req_valid & ~req_write;
  assign wbits = req_wdata[NEVT-1:0];

  sirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (req_addr),
    .kind     (kind),
    .ext_slot (ext_slot)
  );

  assign st_clr = (wr_go && kind == K_STAT) ? wbits : '0;
  assign mk_set = (wr_go && kind == K_EN)   ? wbits : '0;
  assign mk_clr = (wr_go && kind == K_DIS)  ? wbits : '0;

  sirq_status_bank #(.NEVT(NEVT)) u_stat (
    .clk (clk), .rst_n (rst_n), .evt (evt_in), .clr (st_clr), .stat (stat_q)
  );

  sirq_mask_bank #(.NEVT(NEVT)) u_mask (
    .clk (clk), .rst_n (rst_n), .set_v (mk_set), .clr_v (mk_clr), .mask (mask_q)
  );

  sirq_irq_gate #(.NEVT(NEVT)) u_irq (
    .clk (clk), .rst_n (rst_n), .stat (stat_q), .mask (mask_q), .irq (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cen_q <= 1'b0;
    else if (wr_go && kind == K_CEN) cen_q <= req_wdata[0];
  end
  assign ctl_enable = cen_q;

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    logic hit;
    assign hit           = (kind == K_EXT) && (ext_slot == EXT_IDX_W'(e));
    assign ext_wr_sel[e] = wr_go & hit;
    assign ext_rd_sel[e] = rd_go & hit;
  end
  assign ext_wdata = req_wdata;

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_STAT:  rd_mux[NEVT-1:0] = stat_q;
      K_MASK:  rd_mux[NEVT-1:0] = mask_q;
      K_CEN:   rd_mux[0]        = cen_q;
      K_EXT:   rd_mux           = ext_rdata;
      default: rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/serial_irq_regfile_chk.sv
module serial_irq_regfile_chk #(
  parameter int unsigned NEVT   = 7,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [NEVT-1:0]   evt_in,
  input logic [5:0]        ext_wr_sel,
  input logic [5:0]        ext_rd_sel,
  input logic              irq,
  input logic [NEVT-1:0]   stat_q,
  input logic [NEVT-1:0]   mask_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(8'h0C);

  logic            w_stat, w_en, w_dis, rd_req;
  logic [NEVT-1:0] wb, clr_v;
  assign wb     = req_wdata[NEVT-1:0];
  assign w_stat = req_valid && req_write && req_addr == A_STAT;
  assign w_en   = req_valid && req_write && req_addr == A_EN;
  assign w_dis  = req_valid && req_write && req_addr == A_DIS;
  assign rd_req = req_valid && !req_write;
  assign clr_v  = w_stat ? wb : '0;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> ((mask_q & $past(wb)) == $past(wb)));                       // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> ((mask_q & $past(wb)) == '0));                             // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_en || w_dis) |=> $stable(mask_q));                               // R3
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q) & ~$past(clr_v)) == '0));                  // R5
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((stat_q & $past(evt_in)) == $past(evt_in)));     // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dis && wb == '1) |=> ##1 !irq);                                   // R6
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_wr_sel) && (req_write || ext_wr_sel == '0));            // R10
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_rd_sel) && (!req_write || ext_rd_sel == '0));           // R11
  AST_RSP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);                                               // R12
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);                                             // R12
endmodule

bind serial_irq_regfile serial_irq_regfile_chk #(.NEVT(NEVT), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .evt_in     (evt_in),
  .ext_wr_sel (ext_wr_sel),
  .ext_rd_sel (ext_rd_sel),
  .irq        (irq),
  .stat_q     (stat_q),
  .mask_q     (mask_q)
);

// File: tb/serial_irq_regfile_tb.sv
module serial_irq_regfile_tb;
  localparam int NEVT = 7;
  localparam int AW   = 8;
  localparam logic [31:0] EXT_PAT = 32'hA5C3_1E70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NEVT-1:0] evt_in = '0;
  logic [5:0]    ext_wr_sel, ext_rd_sel;
  logic [31:0]   ext_wdata;
  logic [31:0]   ext_rdata = EXT_PAT;
  logic          ctl_enable, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_irq_regfile #(.NEVT(NEVT), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .evt_in(evt_in), .ext_wr_sel(ext_wr_sel),
    .ext_rd_sel(ext_rd_sel), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ctl_enable(ctl_enable), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
    @(negedge clk);
    idle();
    check("R12 no response after write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    drive(1'b0, a, 32'd0);
    @(negedge clk);
    idle();
    check("R12 response after read", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [NEVT-1:0] p);
    evt_in = p;
    @(negedge clk);
    evt_in = '0;
  endtask

  function automatic int slot_of(input int a);
    if (a[1:0] != 2'b00) return -1;
    case (a >> 2)
      0: return 0;  6: return 1;  7: return 2;
      8: return 3;  9: return 4;  10: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [6:0]  m, c, dv, p, st, mk;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 ctl_enable", {31'd0, ctl_enable}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h04, d); check("R1 status", d, 32'd0);
    rd(8'h10, d); check("R1 mask", d, 32'd0);

    // R3 R4 mask sweep
    for (int v = 0; v < 128; v++) begin
      m  = 7'(v);
      dv = 7'((v * 37 + 11) & 127);
      wr(8'h0C, 32'h7F);
      wr(8'h08, {25'h1ABCDEF, m});
      rd(8'h10, d); check("R3 enable sets", d, {25'd0, m});
      wr(8'h0C, {25'h1234567, dv});
      rd(8'h10, d); check("R3 disable clears", d, {25'd0, m & ~dv});
      wr(8'h10, 32'h7F);
      rd(8'h10, d); check("R4 mask read-only", d, {25'd0, m & ~dv});
    end
    rd(8'h08, d); check("R4 enable reads 0", d, 32'd0);
    rd(8'h0C, d); check("R4 disable reads 0", d, 32'd0);

    // R5 R6 status and interrupt sweep
    for (int v = 0; v < 128; v++) begin
      p  = 7'(v);
      c  = 7'((v * 53 + 7) & 127);
      mk = 7'((v * 29 + 3) & 127);
      wr(8'h0C, 32'h7F);
      wr(8'h08, {25'd0, mk});
      wr(8'h04, 32'hFFFF_FFFF);
      pulse(p);
      rd(8'h04, d); check("R5 event sets status", d, {25'd0, p});
      wr(8'h04, {25'd0, c});
      rd(8'h04, d); st = p & ~c;
      check("R5 write-one clears", d, {25'd0, st});
      check("R6 irq OR of status and mask", {31'd0, irq}, {31'd0, |(st & mk)});
    end

    // R6 one-cycle lag
    wr(8'h04, 32'h7F);
    wr(8'h0C, 32'h7F);
    wr(8'h08, 32'h10);
    @(negedge clk);
    check("R6 irq low before event", {31'd0, irq}, 32'd0);
    evt_in = 7'h10;
    @(negedge clk);
    evt_in = '0;
    check("R6 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq one cycle after status", {31'd0, irq}, 32'd1);

    // R7 event beats clear
    wr(8'h04, 32'h7F);
    evt_in = 7'h7F;
    wr(8'h04, 32'h7F);
    evt_in = '0;
    rd(8'h04, d); check("R7 event wins over clear", d, 32'h7F);

    // R8 held level (RX not empty, bit 4)
    wr(8'h04, 32'h7F);
    evt_in = 7'h10;
    @(negedge clk);
    wr(8'h04, 32'h10);
    wr(8'h04, 32'h10);
    rd(8'h04, d); check("R8 held level stays set", d, 32'h10);
    evt_in = '0;
    @(negedge clk);
    rd(8'h04, d); check("R8 latched after level drop", d, 32'h10);
    wr(8'h04, 32'h10);
    rd(8'h04, d); check("R8 clears after drop", d, 32'd0);

    // R9 controller enable
    wr(8'h14, 32'h0000_0001);
    check("R9 ctl_enable set", {31'd0, ctl_enable}, 32'd1);
    rd(8'h14, d); check("R9 readback", d, 32'd1);
    wr(8'h14, 32'hFFFF_FFFE);
    check("R9 ctl_enable cleared by bit0", {31'd0, ctl_enable}, 32'd0);

    // R2 R11 read decode sweep with known state
    wr(8'h04, 32'h7F);
    pulse(7'h41);
    wr(8'h0C, 32'h7F);
    wr(8'h08, 32'h2A);
    wr(8'h14, 32'h1);
    for (int a = 0; a < 256; a++) begin
      int s;
      logic [31:0] e;
      s = slot_of(a);
      drive(1'b0, AW'(a), 32'd0);
      #2;
      check($sformatf("R11 rd strobe a=%0h", a), {26'd0, ext_rd_sel},
            (s >= 0) ? (32'd1 << s) : 32'd0);
      check($sformatf("R10 no wr strobe on read a=%0h", a), {26'd0, ext_wr_sel}, 32'd0);
      @(negedge clk);
      idle();
      if (s >= 0)            e = EXT_PAT;
      else if (a == 8'h04)   e = 32'h41;
      else if (a == 8'h10)   e = 32'h2A;
      else if (a == 8'h14)   e = 32'h1;
      else                   e = 32'd0;
      check($sformatf("R2 read data a=%0h", a), rsp_rdata, e);
    end

    // R2 R10 write decode sweep with zero data bits 6:0 cleared
    for (int a = 0; a < 256; a++) begin
      int s;
      logic [31:0] wd;
      s  = slot_of(a);
      wd = {24'h5A5A00 ^ 24'(a << 8), 8'h80};
      drive(1'b1, AW'(a), wd);
      #2;
      check($sformatf("R10 wr strobe a=%0h", a), {26'd0, ext_wr_sel},
            (s >= 0) ? (32'd1 << s) : 32'd0);
      check($sformatf("R10 wdata a=%0h", a), ext_wdata, wd);
      check($sformatf("R11 no rd strobe on write a=%0h", a), {26'd0, ext_rd_sel}, 32'd0);
      @(negedge clk);
      idle();
    end
    rd(8'h04, d); check("R2 status untouched by sweep", d, 32'h41);
    rd(8'h10, d); check("R2 mask untouched by sweep", d, 32'h2A);

    // R11 neighbour data captured in request cycle
    ext_rdata = 32'h0BAD_F00D;
    rd(8'h20, d); check("R11 rx data passthrough", d, 32'h0BAD_F00D);

    done = 1;
    finish_run();
  end
endmodule